// File: doc/BRIEF.md
# Bus-Mapped Byte Console Port

This block lets a small CPU with an 8-bit data bus talk to a serial terminal through two addresses. A CPU cycle reaches it only while the address decoder's chip-select and the bus data strobe are both low. A single address bit chooses the register. With the bit at 0, a read returns the byte last taken from the receiver and a write queues one byte for the transmitter unchanged. With the bit at 1, a read returns a status byte and a write sends the byte as printable hexadecimal text, one character per nibble.

The serial line itself is not modelled. The receive side is a one-cycle byte pulse (`rx_valid_i`, `rx_data_i`). The transmit side is a valid/ready byte handshake to an external serialiser. The port drives the data bus only while the strobe is held low, and it releases the bus in the same cycle the strobe rises.

Top module: `console_port`

## Requirements
- R1: An access starts only in the first cycle in which `sel_ni` and `ds_ni` are both low. Holding them low for several cycles gives one access. A strobe with either signal high has no effect on the registers or the transmitter.
- R2: A read drives `rdata_o` with `rdata_oe_o` high from the cycle after the access starts. `rdata_oe_o` falls combinationally in the cycle in which `sel_ni` or `ds_ni` goes high.
- R3: A read with `addr_i`=1 returns the status byte. Bit 0 is clear-to-send and bit 1 is receive-pending, so a pending byte adds 0x02. All other bits read as 0.
- R4: A read with `addr_i`=0 returns the stored received byte and clears receive-pending. If a new byte arrives in the same cycle as the read, the read returns the older byte and pending stays set.
- R5: `rx_valid_i` high stores `rx_data_i` and sets receive-pending from the next cycle. A byte that arrives while pending is already set overwrites the stored byte.
- R6: A write with `addr_i`=0 while clear-to-send is set sends exactly one transmit item equal to the written byte.
- R7: A write with `addr_i`=1 while clear-to-send is set sends DATA_W/4 ASCII characters, high nibble first. Values 0-9 map to 0x30-0x39 and values 10-15 map to 0x41-0x46.
- R8: Clear-to-send drops after an accepted write. It stays low until the last item of that write has been accepted by `tx_ready_i`. A write made while it is low is discarded.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold their values.
- R10: After reset, the stored byte is 0, receive-pending is 0, clear-to-send is 1, and `tx_valid_o` and `rdata_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Decoder chip-select, active low |
| ds_ni | input | 1 | Bus data strobe, active low |
| rw_i | input | 1 | 1 = CPU read, 0 = CPU write |
| addr_i | input | 1 | Register select: 0 data, 1 status/hex |
| wdata_i | input | DATA_W | Write data from CPU |
| rdata_o | output | DATA_W | Read data to CPU |
| rdata_oe_o | output | 1 | Bus drive enable for rdata_o |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | DATA_W | Received byte |
| tx_valid_o | output | 1 | Transmit item valid |
| tx_data_o | output | DATA_W | Transmit item |
| tx_ready_i | input | 1 | Serialiser accepts item |

## Verification
The transmit stream is checked against a queue of expected items. Raw writes and hex writes are used with byte values that cover every nibble from 0 to 15, so any fault in character mapping or nibble order shows up. The serialiser's ready signal is given an irregular pattern, and in one phase it is held low. This separates correct stalling from dropped or repeated items and exposes writes that should have been discarded while busy. Receive traffic is run single, overwriting, and colliding with a data read in the same cycle, which shows whether clearing and setting of the pending flag are ordered correctly. Strobes with only one select signal low, and a strobe held low for several cycles, show whether accesses are decoded and counted correctly.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int CTS_BIT = 0;
  localparam int RXP_BIT = 1;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_RAW  = 2'd1,
    TX_HEX  = 2'd2
  } tx_state_e;

  function automatic logic [7:0] hex_char(input logic [3:0] nib);
    if (nib < 4'd10) return 8'h30 + {4'h0, nib};
    else             return 8'h37 + {4'h0, nib};
  endfunction
endpackage

// File: rtl/console_bus_dec.sv
module console_bus_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic ds_ni,
  input  logic rw_i,
  input  logic addr_i,
  output logic active_o,
  output logic rd_data_o,
  output logic rd_stat_o,
  output logic wr_raw_o,
  output logic wr_hex_o
);
  logic act_q;
  logic start;

  assign active_o = ~(sel_ni | ds_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= active_o;
  end

  // one access per strobe low period
  assign start     = active_o & ~act_q;
  assign rd_data_o = start &  rw_i & ~addr_i;
  assign rd_stat_o = start &  rw_i &  addr_i;
  assign wr_raw_o  = start & ~rw_i & ~addr_i;
  assign wr_hex_o  = start & ~rw_i &  addr_i;
endmodule

// File: rtl/console_rx.sv
module console_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      pend_o <= 1'b0;
    end else begin
      if (rx_valid_i)  byte_o <= rx_data_i;
      // arrival wins over a simultaneous clear
      if (rx_valid_i)  pend_o <= 1'b1;
      else if (clr_i)  pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/console_tx.sv
module console_tx
  import console_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_raw_i,
  input  logic              wr_hex_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              cts_o
);
  localparam int NIB   = DATA_W / 4;
  localparam int IDX_W = (NIB > 1) ? $clog2(NIB) : 1;

  tx_state_e         state_q;
  logic [DATA_W-1:0] byte_q;
  logic [IDX_W-1:0]  idx_q;
  logic [3:0]        nib;

  assign cts_o      = (state_q == TX_IDLE);
  assign tx_valid_o = ~cts_o;
  assign nib        = byte_q[idx_q*4 +: 4];

  always_comb begin
    case (state_q)
      TX_RAW:  tx_data_o = byte_q;
      TX_HEX:  tx_data_o = DATA_W'(hex_char(nib));
      default: tx_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      byte_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (wr_raw_i) begin
            state_q <= TX_RAW;
            byte_q  <= wdata_i;
          end else if (wr_hex_i) begin
            state_q <= TX_HEX;
            byte_q  <= wdata_i;
            idx_q   <= IDX_W'(NIB - 1);
          end
        end
        TX_RAW: if (tx_ready_i) state_q <= TX_IDLE;
        TX_HEX: begin
          if (tx_ready_i) begin
            if (idx_q == '0) state_q <= TX_IDLE;
            else             idx_q   <= idx_q - 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/console_port.sv
module console_port
  import console_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              ds_ni,
  input  logic              rw_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  logic              active, rd_data, rd_stat, wr_raw, wr_hex;
  logic [DATA_W-1:0] rx_byte, status;
  logic              rx_pend, cts, oe_q;

  console_bus_dec u_dec (
    .clk_i, .rst_ni, .sel_ni, .ds_ni, .rw_i, .addr_i,
    .active_o (active),
    .rd_data_o(rd_data),
    .rd_stat_o(rd_stat),
    .wr_raw_o (wr_raw),
    .wr_hex_o (wr_hex)
  );

  console_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i,
    .clr_i (rd_data),
    .byte_o(rx_byte),
    .pend_o(rx_pend)
  );

  console_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_raw_i(wr_raw),
    .wr_hex_i(wr_hex),
    .wdata_i,
    .tx_ready_i,
    .tx_valid_o,
    .tx_data_o,
    .cts_o(cts)
  );

  always_comb begin
    status          = '0;
    status[CTS_BIT] = cts;
    status[RXP_BIT] = rx_pend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (rd_data)      rdata_o <= rx_byte;
      else if (rd_stat) rdata_o <= status;
      if (rd_data | rd_stat) oe_q <= 1'b1;
      else if (!active)      oe_q <= 1'b0;
    end
  end

  // bus released as soon as the strobe rises
  assign rdata_oe_o = oe_q & active;
endmodule

// File: rtl/console_port_chk.sv
module console_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_ni,
  input logic              ds_ni,
  input logic              rdata_oe_o,
  input logic              rx_valid_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              rx_pend_i,
  input logic              cts_i
);
  p_bus_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (!sel_ni && !ds_ni));

  p_rx_sets_pend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> rx_pend_i);

  p_busy_no_cts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !cts_i);

  p_cts_low_sends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cts_i |-> tx_valid_o);

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind console_port console_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .sel_ni, .ds_ni, .rdata_oe_o, .rx_valid_i,
  .tx_valid_o, .tx_ready_i, .tx_data_o,
  .rx_pend_i(rx_pend),
  .cts_i    (cts)
);

// File: tb/console_port_test.sv
module console_port_test;
  localparam int W = 8;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         sel_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1, addr_i = 1'b0;
  logic [W-1:0] wdata_i = '0, rdata_o, rx_data_i = '0, tx_data_o;
  logic         rdata_oe_o, rx_valid_i = 1'b0, tx_valid_o, tx_ready_i = 1'b0;

  int checks = 0, fails = 0, tick = 0;
  bit stall = 1'b0, done = 1'b0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  console_port #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni, .sel_ni, .ds_ni, .rw_i, .addr_i, .wdata_i,
    .rdata_o, .rdata_oe_o, .rx_valid_i, .rx_data_i,
    .tx_valid_o, .tx_data_o, .tx_ready_i
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hx(input logic [3:0] n);
    return (n < 10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  // monitor: decides ready for the coming edge and scores the handshake
  always @(negedge clk) begin
    if (rst_ni) begin
      tick++;
      tx_ready_i = !stall && ((tick % 3) != 1);
      if (tx_valid_o && tx_ready_i) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6/R7/R8: unexpected tx %h expected none", tx_data_o);
        end else check("R6/R7 tx stream", tx_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic bus_read(input logic a, input string req, input logic [W-1:0] exp);
    @(negedge clk); sel_ni = 0; ds_ni = 0; rw_i = 1; addr_i = a;
    @(negedge clk);
    check({req, " oe"}, W'(rdata_oe_o), W'(1));
    check(req, rdata_o, exp);
    ds_ni = 1; #1;
    check("R2 release", W'(rdata_oe_o), W'(0));
    sel_ni = 1;
  endtask

  task automatic bus_write(input logic a, input logic [W-1:0] d, input bit accepted);
    @(negedge clk); sel_ni = 0; ds_ni = 0; rw_i = 0; addr_i = a; wdata_i = d;
    if (accepted) begin
      if (!a) exp_q.push_back(d);
      else for (int i = W/4-1; i >= 0; i--) exp_q.push_back(hx(d[i*4 +: 4]));
    end
    @(negedge clk); sel_ni = 1; ds_ni = 1; rw_i = 1;
  endtask

  task automatic rx_push(input logic [W-1:0] d);
    @(negedge clk); rx_valid_i = 1; rx_data_i = d;
    @(negedge clk); rx_valid_i = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R10 reset state
    check("R10 tx_valid", W'(tx_valid_o), W'(0));
    check("R10 oe", W'(rdata_oe_o), W'(0));
    bus_read(1, "R10 R3 status", 8'h01);
    bus_read(0, "R10 data", 8'h00);

    // R5 receive and overwrite, R3 pending bit, R4 clear
    rx_push(8'hA5);
    bus_read(1, "R5 R3 status pend", 8'h03);
    rx_push(8'h3C);
    bus_read(0, "R5 overwrite", 8'h3C);
    bus_read(1, "R4 cleared", 8'h01);

    // R4 read colliding with an arrival
    rx_push(8'h11);
    @(negedge clk); sel_ni = 0; ds_ni = 0; rw_i = 1; addr_i = 0;
    rx_valid_i = 1; rx_data_i = 8'h22;
    @(negedge clk); rx_valid_i = 0;
    check("R4 collide old byte", rdata_o, 8'h11);
    ds_ni = 1; sel_ni = 1;
    bus_read(1, "R4 pend kept", 8'h03);
    bus_read(0, "R4 new byte", 8'h22);

    // R1 partial selects do nothing
    rx_push(8'h5A);
    @(negedge clk); sel_ni = 1; ds_ni = 0; rw_i = 1; addr_i = 0;
    @(negedge clk); check("R1 no oe ds only", W'(rdata_oe_o), W'(0));
    ds_ni = 1; sel_ni = 0;
    @(negedge clk); check("R1 no oe sel only", W'(rdata_oe_o), W'(0));
    sel_ni = 1; rw_i = 0; ds_ni = 0; wdata_i = 8'hEE;
    @(negedge clk); ds_ni = 1; rw_i = 1;
    repeat (4) @(negedge clk);
    bus_read(1, "R1 pend untouched", 8'h03);
    bus_read(0, "R1 byte", 8'h5A);

    // R6 raw writes
    bus_write(0, 8'h41, 1); drain();
    bus_write(0, 8'h00, 1); drain();
    bus_write(0, 8'hFF, 1); drain();

    // R1 long strobe gives one access
    @(negedge clk); sel_ni = 0; ds_ni = 0; rw_i = 0; addr_i = 0; wdata_i = 8'h7E;
    exp_q.push_back(8'h7E);
    repeat (5) @(negedge clk);
    sel_ni = 1; ds_ni = 1; rw_i = 1;
    drain();

    // R7 hex over all nibble values
    bus_write(1, 8'h01, 1); drain();
    bus_write(1, 8'h9A, 1); drain();
    bus_write(1, 8'hBF, 1); drain();
    bus_write(1, 8'h23, 1); drain();
    bus_write(1, 8'h45, 1); drain();
    bus_write(1, 8'h67, 1); drain();
    bus_write(1, 8'h8C, 1); drain();
    bus_write(1, 8'hDE, 1); drain();

    // R8/R9 busy under stall, write discarded
    stall = 1;
    bus_write(1, 8'h5C, 1);
    repeat (3) @(negedge clk);
    check("R9 valid held", W'(tx_valid_o), W'(1));
    check("R9 data held", tx_data_o, 8'h35);
    bus_read(1, "R8 status busy", 8'h00);
    bus_write(0, 8'h77, 0);
    bus_write(1, 8'h12, 0);
    stall = 0;
    drain();
    bus_read(1, "R8 status idle", 8'h01);
    bus_write(0, 8'h99, 1); drain();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6/R7: got %0d pending items expected 0", exp_q.size());
    end
    done = 1;
    finish_run();
  end
endmodule